// File: doc/BRIEF.md
# Two-Class Output Port with Preemption and Replay

This block is one egress port of a 100 Mbit/s layer-2 switch that carries two classes of traffic on one line. Scheduled (time-triggered) frames enter as a byte stream and go straight to the line through a fixed-length delay line. They are never stored in frame memory, so each of their bytes leaves exactly `CLEAR_DELAY` cycles after it arrives. Best-effort (event-triggered) frames are stored whole in a circular byte memory. They are sent in arrival order, and only when no scheduled traffic is on its way.

The delay line gives advance warning. When a scheduled frame starts arriving while a best-effort frame is on the line, the best-effort frame is cut off at once. The line then stays idle until the scheduled bytes come out. The cut frame keeps its place at the head of the queue and is sent again from its first byte once the line is free. A best-effort frame that does not fit in the remaining memory is discarded entirely, and a drop counter counts it. Frames already queued are not disturbed.

At 100 Mbit/s one byte lasts 80 ns, so the default of 50 byte-cycles gives a 4 µs clearance window. Each input stream marks a frame by holding its valid flag high for the frame's bytes, one byte per cycle. The output uses the same convention.

Top module: `preempt_port`

## Requirements
- R1: After reset, `outValid` is 0 and `dropCount` is 0.
- R2: A byte presented on `ttData` with `ttValid`=1 in cycle n appears unchanged on `outData` with `outValid`=1 in cycle n+`CLEAR_DELAY`. A scheduled frame leaves as one contiguous run of the same length.
- R3: A best-effort frame that is fully received while no scheduled traffic is present is sent in full and in byte order, as one contiguous run.
- R4: No best-effort byte is sent while `ttValid` is 1 or while scheduled bytes are in the delay line. A best-effort frame that waits behind a scheduled frame starts exactly two cycles after the last scheduled output byte, leaving one idle cycle between them.
- R5: If `ttValid` rises while a best-effort frame is being sent, that frame's last output byte is in the same cycle as the first `ttValid`, and `outValid` is 0 from the next cycle until the scheduled bytes appear.
- R6: A best-effort frame that was cut off is sent again from its first byte, in full. It starts two cycles after the scheduled frame that cut it ends.
- R7: Queued best-effort frames leave in the order in which they were received.
- R8: A best-effort frame arriving when the memory (2^`BUF_AW` bytes) cannot hold all of it is discarded whole, and `dropCount` increases by exactly one for it. Frames queued earlier are sent intact.
- R9: After the queue drains, new best-effort frames are accepted and sent again, and `dropCount` keeps its value.
- R10: Best-effort input frames are separated by at least one cycle with `etValid`=0. A one-byte frame is a valid frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ttValid | input | 1 | Scheduled-frame byte strobe, high for each byte of a frame |
| ttData | input | 8 | Scheduled-frame byte |
| etValid | input | 1 | Best-effort byte strobe, high for each byte of a frame |
| etData | input | 8 | Best-effort byte |
| outValid | output | 1 | Line byte strobe, high for each byte of an outgoing frame |
| outData | output | 8 | Line byte |
| dropCount | output | CNT_W | Count of discarded best-effort frames, wrapping |

## Verification
The overflow path is the hardest to reach from the ports, because the queue drains onto the line as soon as the line is idle. The bench holds a long scheduled frame on `ttValid` so that the line stays reserved. Behind it, it pushes best-effort frames until one overflows partway through, then sends a short frame that fits and another that overflows again. After the line frees, it checks that only the fitting frames come out and that they are intact. Preemption is reached by waiting at the output until a best-effort frame is several bytes into transmission before starting a scheduled frame. The bench then checks the truncated prefix, the cut-off cycle, the scheduled latency and the full replay.

// File: rtl/preempt_port_pkg.sv
package preempt_port_pkg;

  // Control -> datapath strobes
  typedef struct packed {
    logic loadRd;     // rewind read pointer to head of queue
    logic emitEt;     // drive current queue byte to the line
    logic freeFrame;  // head frame fully sent, free its storage
    logic writeByte;  // store held input byte
    logic commit;     // held byte is the last of its frame
    logic dropFrame;  // discard the frame being received
  } portStrobes_t;

  // Datapath -> control status
  typedef struct packed {
    logic ttBusy;     // scheduled traffic at input or in delay line
    logic frameAvail; // at least one complete frame queued
    logic rdEof;      // byte under read pointer ends its frame
    logic bufFull;    // no free byte in queue memory
    logic heldValid;  // an input byte is waiting to be stored
  } portStatus_t;

endpackage

// File: rtl/preempt_port_dpath.sv
module preempt_port_dpath
  import preempt_port_pkg::*;
#(
  parameter int CLEAR_DELAY = 50,
  parameter int BUF_AW      = 8,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ttValid,
  input  logic [7:0]       ttData,
  input  logic             etValid,
  input  logic [7:0]       etData,
  input  portStrobes_t     strb,
  output portStatus_t      stat,
  output logic             tailValid,
  output logic             lineOccupied,
  output logic             outValid,
  output logic [7:0]       outData,
  output logic [CNT_W-1:0] dropCount
);

  localparam int LINE  = CLEAR_DELAY - 1;   // output register is the last stage
  localparam int DEPTH = 1 << BUF_AW;
  localparam int PW    = BUF_AW + 1;
  localparam logic [PW-1:0] ONE = PW'(1);

  // Scheduled path: memoryless shift line
  logic [LINE-1:0]      lineV;
  logic [LINE-1:0][7:0] lineD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineV <= '0;
      lineD <= '0;
    end else begin
      lineV <= {lineV[LINE-2:0], ttValid};
      lineD <= {lineD[LINE-2:0], ttData};
    end
  end

  assign tailValid    = lineV[LINE-1];
  assign lineOccupied = |lineV;

  // Best-effort queue memory: {eof, byte}
  logic [8:0]    mem [DEPTH];
  logic [PW-1:0] headPtr, tailPtr, wrPtr, rdPtr, frameCount;
  logic [7:0]    heldData;
  logic          heldValid;
  logic [8:0]    rdWord;

  assign rdWord = mem[rdPtr[BUF_AW-1:0]];

  always_ff @(posedge clk) begin
    if (strb.writeByte) mem[wrPtr[BUF_AW-1:0]] <= {strb.commit, heldData};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr    <= '0;
      tailPtr    <= '0;
      wrPtr      <= '0;
      rdPtr      <= '0;
      frameCount <= '0;
      heldData   <= '0;
      heldValid  <= 1'b0;
      dropCount  <= '0;
    end else begin
      heldData  <= etData;
      heldValid <= etValid;
      if (strb.dropFrame)      wrPtr <= tailPtr;
      else if (strb.writeByte) wrPtr <= wrPtr + ONE;
      if (strb.commit)         tailPtr <= wrPtr + ONE;
      if (strb.loadRd)         rdPtr <= headPtr;
      else if (strb.emitEt)    rdPtr <= rdPtr + ONE;
      if (strb.freeFrame)      headPtr <= rdPtr + ONE;
      frameCount <= frameCount + PW'(strb.commit) - PW'(strb.freeFrame);
      if (strb.dropFrame)      dropCount <= dropCount + CNT_W'(1);
    end
  end

  assign stat.ttBusy     = ttValid | lineOccupied;
  assign stat.frameAvail = (frameCount != '0);
  assign stat.rdEof      = rdWord[8];
  assign stat.bufFull    = ((wrPtr - headPtr) == PW'(DEPTH));
  assign stat.heldValid  = heldValid;

  // Line register: scheduled bytes win, otherwise the queue byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else if (tailValid) begin
      outValid <= 1'b1;
      outData  <= lineD[LINE-1];
    end else if (strb.emitEt) begin
      outValid <= 1'b1;
      outData  <= rdWord[7:0];
    end else begin
      outValid <= 1'b0;
    end
  end

endmodule

// File: rtl/preempt_port_ctrl.sv
module preempt_port_ctrl
  import preempt_port_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         etValid,
  input  portStatus_t  stat,
  output portStrobes_t strb
);

  logic txSend;      // a queued frame is on the line
  logic discarding;  // rest of the current input frame is thrown away

  always_comb begin
    strb = '0;
    // transmit side
    if (!txSend) begin
      strb.loadRd = stat.frameAvail && !stat.ttBusy;
    end else if (!stat.ttBusy) begin
      strb.emitEt    = 1'b1;
      strb.freeFrame = stat.rdEof;
    end
    // receive side: the held byte is last when the input has gone low
    if (stat.heldValid && !discarding) begin
      if (stat.bufFull) begin
        strb.dropFrame = 1'b1;
      end else begin
        strb.writeByte = 1'b1;
        strb.commit    = !etValid;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSend     <= 1'b0;
      discarding <= 1'b0;
    end else begin
      if (!txSend)                        txSend <= strb.loadRd;
      else if (stat.ttBusy || stat.rdEof) txSend <= 1'b0;

      if (strb.dropFrame && etValid)      discarding <= 1'b1;
      else if (discarding && !etValid)    discarding <= 1'b0;
    end
  end

endmodule

// File: rtl/preempt_port.sv
module preempt_port
  import preempt_port_pkg::*;
#(
  parameter int CLEAR_DELAY = 50,   // byte times, at least 3
  parameter int BUF_AW      = 8,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ttValid,
  input  logic [7:0]       ttData,
  input  logic             etValid,
  input  logic [7:0]       etData,
  output logic             outValid,
  output logic [7:0]       outData,
  output logic [CNT_W-1:0] dropCount
);

  portStrobes_t portStrb;
  portStatus_t  portStat;
  logic         tailValid;
  logic         lineOccupied;

  preempt_port_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .etValid (etValid),
    .stat    (portStat),
    .strb    (portStrb)
  );

  preempt_port_dpath #(
    .CLEAR_DELAY (CLEAR_DELAY),
    .BUF_AW      (BUF_AW),
    .CNT_W       (CNT_W)
  ) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .ttValid      (ttValid),
    .ttData       (ttData),
    .etValid      (etValid),
    .etData       (etData),
    .strb         (portStrb),
    .stat         (portStat),
    .tailValid    (tailValid),
    .lineOccupied (lineOccupied),
    .outValid     (outValid),
    .outData      (outData),
    .dropCount    (dropCount)
  );

endmodule

// File: rtl/preempt_port_checker.sv
module preempt_port_checker
  import preempt_port_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             ttValid,
  input logic             outValid,
  input logic [CNT_W-1:0] dropCount,
  input logic             tailValid,
  input logic             lineOccupied,
  input portStatus_t      stat,
  input portStrobes_t     strb
);

  // R5: scheduled input clears the line on the next cycle unless scheduled bytes exit
  assert_tt_clears_line_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ttValid && !tailValid) |=> !outValid);

  // R4: while scheduled bytes travel the line but none exits, nothing is sent
  assert_line_blocks_et_R4: assert property (@(posedge clk) disable iff (!rstN)
    (lineOccupied && !tailValid) |=> !outValid);

  // R8: a full memory is never written
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    stat.bufFull |-> !strb.writeByte);

  // R8: the drop counter moves by one at a time
  assert_drop_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    (dropCount != $past(dropCount)) |-> (dropCount == $past(dropCount) + CNT_W'(1)));

  // R10: a held input byte is either stored or dropped, never both
  assert_single_rx_action_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.writeByte, strb.dropFrame}));

endmodule

bind preempt_port preempt_port_checker #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .ttValid      (ttValid),
  .outValid     (outValid),
  .dropCount    (dropCount),
  .tailValid    (tailValid),
  .lineOccupied (lineOccupied),
  .stat         (portStat),
  .strb         (portStrb)
);

// File: tb/sim_preempt_port.sv
`timescale 1ns/1ps
module sim_preempt_port;

  localparam int D = 50;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ttValid = 1'b0;
  logic [7:0] ttData = '0;
  logic       etValid = 1'b0;
  logic [7:0] etData = '0;
  logic       outValid;
  logic [7:0] outData;
  logic [7:0] dropCount;

  int  checks = 0;
  int  errors = 0;
  int  cyc = 0;
  bit  done = 0;

  logic [7:0] outBytes[$];
  int         frLen[$];
  int         frStart[$];
  bit         inFrame = 0;
  int         curLen = 0;

  preempt_port u0 (
    .clk(clk), .rstN(rstN),
    .ttValid(ttValid), .ttData(ttData),
    .etValid(etValid), .etData(etData),
    .outValid(outValid), .outData(outData),
    .dropCount(dropCount)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Output monitor: split the line into frames
  always @(negedge clk) begin
    if (outValid) begin
      if (!inFrame) begin
        frStart.push_back(cyc);
        curLen = 0;
        inFrame = 1;
      end
      outBytes.push_back(outData);
      curLen++;
    end else if (inFrame) begin
      frLen.push_back(curLen);
      inFrame = 0;
    end
  end

  function automatic logic [7:0] ttByte(int id, int i);
    return 8'(id * 37 + i * 5 + 128);
  endfunction

  function automatic logic [7:0] etByte(int id, int i);
    return 8'(id * 19 + i * 3 + 1);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int frOff(int k);
    int s = 0;
    for (int j = 0; j < k; j++) s += frLen[j];
    return s;
  endfunction

  task automatic checkBytes(input int k, input string req, input bit isTt, input int id);
    int mism = 0;
    int off;
    if (k >= frLen.size()) begin
      check(0, req, "frame present", frLen.size(), k + 1);
      return;
    end
    off = frOff(k);
    for (int i = 0; i < frLen[k]; i++) begin
      if (outBytes[off + i] != (isTt ? ttByte(id, i) : etByte(id, i))) mism++;
    end
    check(mism == 0, req, "byte mismatches", mism, 0);
  endtask

  task automatic checkFrame(input int k, input string req, input bit isTt,
                            input int id, input int expLen);
    if (k >= frLen.size()) begin
      check(0, req, "frame present", frLen.size(), k + 1);
      return;
    end
    check(frLen[k] == expLen, req, "frame length", frLen[k], expLen);
    checkBytes(k, req, isTt, id);
  endtask

  task automatic clearLog();
    outBytes.delete();
    frLen.delete();
    frStart.delete();
  endtask

  task automatic waitQuiet();
    int idle = 0;
    while (idle < 100) begin
      @(negedge clk);
      if (outValid) idle = 0; else idle++;
    end
  endtask

  task automatic sendTt(input int id, input int len, output int startCyc);
    @(negedge clk);
    startCyc = cyc;
    for (int i = 0; i < len; i++) begin
      ttValid = 1'b1;
      ttData  = ttByte(id, i);
      @(negedge clk);
    end
    ttValid = 1'b0;
  endtask

  task automatic sendEt(input int id, input int len);
    @(negedge clk);
    for (int i = 0; i < len; i++) begin
      etValid = 1'b1;
      etData  = etByte(id, i);
      @(negedge clk);
    end
    etValid = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk);
    check(outValid == 1'b0, "R1", "outValid after reset", outValid, 0);
    check(dropCount == 8'd0, "R1", "dropCount after reset", dropCount, 0);
  endtask

  task automatic testTtLatency();
    int s;
    clearLog();
    sendTt(1, 6, s);
    waitQuiet();
    check(frLen.size() == 1, "R2", "frame count", frLen.size(), 1);
    if (frStart.size() > 0)
      check(frStart[0] == s + D, "R2", "first byte cycle", frStart[0], s + D);
    checkFrame(0, "R2", 1, 1, 6);
  endtask

  task automatic testEtBasic();
    clearLog();
    sendEt(2, 5);
    waitQuiet();
    check(frLen.size() == 1, "R3", "frame count", frLen.size(), 1);
    checkFrame(0, "R3", 0, 2, 5);
  endtask

  task automatic testEtOrder();
    clearLog();
    sendEt(3, 1);   // R10: one-byte frame
    sendEt(4, 4);
    sendEt(5, 2);
    waitQuiet();
    check(frLen.size() == 3, "R7", "frame count", frLen.size(), 3);
    checkFrame(0, "R10", 0, 3, 1);
    checkFrame(1, "R7", 0, 4, 4);
    checkFrame(2, "R7", 0, 5, 2);
  endtask

  task automatic testHoldOff();
    int s;
    int ttEnd;
    clearLog();
    fork
      sendTt(6, 8, s);
      begin
        @(negedge clk);
        sendEt(7, 4);
      end
    join
    waitQuiet();
    check(frLen.size() == 2, "R4", "frame count", frLen.size(), 2);
    checkFrame(0, "R4", 1, 6, 8);
    checkFrame(1, "R4", 0, 7, 4);
    if (frStart.size() == 2) begin
      ttEnd = frStart[0] + frLen[0] - 1;
      check(frStart[0] == s + D, "R2", "scheduled start", frStart[0], s + D);
      check(frStart[1] == ttEnd + 2, "R4", "waiting frame start", frStart[1], ttEnd + 2);
    end
  endtask

  task automatic testPreempt();
    int s;
    int ttEnd;
    clearLog();
    sendEt(8, 20);
    while (!outValid) @(negedge clk);
    repeat (5) @(negedge clk);
    sendTt(9, 6, s);
    waitQuiet();
    check(frLen.size() == 3, "R5", "frame count", frLen.size(), 3);
    if (frLen.size() == 3) begin
      check(frLen[0] >= 1 && frLen[0] < 20, "R5", "truncated length", frLen[0], 7);
      check(frStart[0] + frLen[0] - 1 == s, "R5", "cut-off cycle",
            frStart[0] + frLen[0] - 1, s);
      checkBytes(0, "R5", 0, 8);
      check(frStart[1] == s + D, "R5", "scheduled start", frStart[1], s + D);
      checkFrame(1, "R5", 1, 9, 6);
      ttEnd = frStart[1] + frLen[1] - 1;
      check(frStart[2] == ttEnd + 2, "R6", "replay start", frStart[2], ttEnd + 2);
      checkFrame(2, "R6", 0, 8, 20);
    end
  endtask

  task automatic testOverflow();
    int s;
    clearLog();
    fork
      sendTt(10, 400, s);
      begin
        repeat (3) @(negedge clk);
        sendEt(20, 100);
        sendEt(21, 100);
        sendEt(22, 100);   // overflows partway: dropped
        sendEt(23, 50);    // fits: 250 of 256 bytes
        sendEt(24, 10);    // overflows again: dropped
      end
    join
    waitQuiet();
    check(dropCount == 8'd2, "R8", "dropCount", dropCount, 2);
    check(frLen.size() == 4, "R8", "frame count", frLen.size(), 4);
    checkFrame(0, "R8", 1, 10, 400);
    checkFrame(1, "R8", 0, 20, 100);
    checkFrame(2, "R8", 0, 21, 100);
    checkFrame(3, "R8", 0, 23, 50);
    clearLog();
    sendEt(25, 12);
    waitQuiet();
    check(frLen.size() == 1, "R9", "frame count", frLen.size(), 1);
    checkFrame(0, "R9", 0, 25, 12);
    check(dropCount == 8'd2, "R9", "dropCount kept", dropCount, 2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testTtLatency();
    testEtBasic();
    testEtOrder();
    testHoldOff();
    testPreempt();
    testOverflow();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL all watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule